// File: doc/BRIEF.md
# Serial Receiver with Idle-Line Detection and Mute Wakeup

This block is the receive half of an asynchronous serial port. It samples a serial line on a 16x oversampling clock enable and recovers characters of 7, 8 or 9 data bits. Each character is framed by one start bit and one stop bit, and data arrives least significant bit first. Each recovered character is presented right-justified together with a one-cycle data-valid strobe. A stop bit sampled low raises a sticky framing-error flag, and the character is still delivered.

The receiver watches for an idle line. One idle character is a run of logic-1 bit periods as long as a whole frame: the data bits plus two. A 3-bit code selects how many consecutive idle characters are needed before the sticky idle flag rises, from 1 up to 128 in powers of two. A line-type select chooses where the run of ones may begin:
- from the start bit, so that trailing ones in the data count toward the run;
- only after the stop bit.

A mute mode suppresses received data until the line goes idle or until a character arrives with its top data bit set. The receive shifter can take its input from one of three places: the external receive pin, the internal transmit output, or a shared single-wire line.

Top module: `uart_idle_rx`

## Requirements
- R1: With `loop_mode`=0 the receiver decodes `rxd_pin`. With `loop_mode`=1 and `src_sel`=0 it decodes `tx_loop_in` and ignores `rxd_pin`. With `loop_mode`=1 and `src_sel`=1 it decodes `txd_line`.
- R2: `src_sel` has no effect while `loop_mode`=0; characters on `rxd_pin` are decoded unchanged.
- R3: Character length is 7 data bits when the latched `len7`=1. Otherwise it is 9 when the latched `len9`=1, and 8 when both are 0. `rx_data` is right-justified, LSB-first data, and its bits at and above the character length read 0.
- R4: `len7` and `len9` are captured only while `rx_en`=0; changes made while enabled do not alter the character length.
- R5: A start bit must still be low at its middle (eighth oversample) to be accepted. Data bits and the stop bit are sampled at the sixteenth oversample of their bit. `rx_valid` is a one-cycle pulse per delivered character.
- R6: A stop bit sampled as 0 sets `frame_err`, and the character is still delivered with `rx_valid`. `frame_err` stays set until `rx_en` is driven to 0.
- R7: `idle_flag` rises after 2^`idle_code` consecutive idle characters. One idle character is (data bits + 2) bit periods of logic 1.
- R8: With `idle_after_stop`=0 the count of ones starts at the accepted start bit, so trailing 1 data bits and the stop bit count. A received 0xFF in 8-bit mode then completes an idle character one bit period after its stop bit. With `idle_after_stop`=1 counting starts only after the stop bit.
- R9: `idle_flag` stays set until an `idle_clr` pulse, and `idle_clr` takes priority over a new detection. After a clear, `idle_flag` cannot rise again until a new character has been received.
- R10: A `mute_req` pulse sets `muted`. With `wake_addr`=0, detection of the idle line clears `muted`. Characters received while muted give no `rx_valid` and add nothing to the idle count.
- R11: With `wake_addr`=1 a muted receiver clears `muted` on a character whose top data bit (bit length-1) is 1. That character is delivered with `rx_valid`; characters with a 0 top bit stay suppressed.
- R12: After reset, `rx_valid`, `idle_flag`, `frame_err` and `muted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rx_en | input | 1 | Receiver enable; 0 clears state and latches length selects |
| rxd_pin | input | 1 | External receive pin |
| tx_loop_in | input | 1 | Internal transmit serial output for loopback |
| txd_line | input | 1 | Shared single-wire line |
| loop_mode | input | 1 | Selects loopback or single-wire routing |
| src_sel | input | 1 | With loop_mode: 0 internal loopback, 1 single-wire |
| len7 | input | 1 | Seven-data-bit select |
| len9 | input | 1 | Nine-data-bit select when len7 is 0 |
| idle_code | input | IDLE_CODE_W | Idle characters needed: 2^code |
| idle_after_stop | input | 1 | 0: count ones from start bit, 1: from after stop bit |
| wake_addr | input | 1 | Mute exit: 0 idle line, 1 address mark |
| mute_req | input | 1 | One-cycle pulse entering mute state |
| idle_clr | input | 1 | One-cycle write-one-to-clear for idle_flag |
| rx_data | output | DATA_W | Received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| idle_flag | output | 1 | Sticky idle-line flag |
| frame_err | output | 1 | Sticky framing-error flag |
| muted | output | 1 | Current mute (wakeup) state |

## Verification
The assertions take for granted three things about the inputs:
- `os_tick` is a single-cycle enable;
- `mute_req` and `idle_clr` are single-cycle pulses;
- the length selects do not matter while the receiver is enabled, because they are latched only while it is disabled.

The stimulus drives the serial line only on bit-period boundaries, exactly 32 clocks per bit, and it never changes routing while a frame is in flight. Before any check that depends on the idle count or on the armed state, it leaves the line idle long enough for every pending idle detection to finish.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_START = 2'd1,
      FR_DATA  = 2'd2,
      FR_STOP  = 2'd3
   } fr_state_t;

   // one sampled bit period, reported by the framer
   typedef struct packed {
      logic stb;
      logic val;
      logic is_data;
      logic is_stop;
   } bit_evt_t;

endpackage

// File: rtl/uart_rx_srcmux.sv
module uart_rx_srcmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_mode,
   input  logic src_sel,
   input  logic rxd_pin,
   input  logic tx_loop_in,
   input  logic txd_line,
   output logic rx_s
);

   logic raw_in;

   always_comb begin
      if (!loop_mode)   raw_in = rxd_pin;
      else if (src_sel) raw_in = txd_line;
      else              raw_in = tx_loop_in;
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = raw_in;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 1'b1;
            else        sync_q <= raw_in;
         end
         assign rx_s = sync_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
         end
         assign rx_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
   import uart_rx_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 9
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enable,
   input  logic                          os_tick,
   input  logic                          rx_s,
   input  logic [$clog2(DATA_W+1)-1:0]   nbits,
   output logic                          start_ok,
   output bit_evt_t                      evt,
   output logic                          char_done,
   output logic [DATA_W-1:0]             char_data,
   output logic                          stop_ok
);

   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = $clog2(DATA_W+1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR-1);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR/2-1);

   fr_state_t          state;
   logic [CNT_W-1:0]   os_cnt;
   logic [BIT_W-1:0]   bit_idx;
   logic [DATA_W-1:0]  shreg;
   logic               line_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FR_IDLE;
         os_cnt    <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         line_hi   <= 1'b0;
         start_ok  <= 1'b0;
         evt       <= '0;
         char_done <= 1'b0;
         char_data <= '0;
         stop_ok   <= 1'b0;
      end else begin
         start_ok  <= 1'b0;
         evt       <= '0;
         char_done <= 1'b0;
         if (!enable) begin
            state   <= FR_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            line_hi <= 1'b0;
         end else if (os_tick) begin
            unique case (state)
               FR_IDLE: begin
                  if (line_hi && !rx_s) begin
                     state  <= FR_START;
                     os_cnt <= '0;
                  end else begin
                     line_hi <= rx_s;
                     os_cnt  <= os_cnt + 1'b1;
                     if (os_cnt == LAST) begin
                        evt.stb <= 1'b1;
                        evt.val <= rx_s;
                     end
                  end
               end
               FR_START: begin
                  if (os_cnt == HALF) begin
                     os_cnt <= '0;
                     if (!rx_s) begin
                        state    <= FR_DATA;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        start_ok <= 1'b1;
                     end else begin
                        state <= FR_IDLE;
                     end
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               FR_DATA: begin
                  if (os_cnt == LAST) begin
                     os_cnt          <= '0;
                     shreg[bit_idx]  <= rx_s;
                     evt.stb         <= 1'b1;
                     evt.val         <= rx_s;
                     evt.is_data     <= 1'b1;
                     if (bit_idx == nbits - 1'b1) state   <= FR_STOP;
                     else                         bit_idx <= bit_idx + 1'b1;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               FR_STOP: begin
                  if (os_cnt == LAST) begin
                     os_cnt      <= '0;
                     evt.stb     <= 1'b1;
                     evt.val     <= rx_s;
                     evt.is_stop <= 1'b1;
                     char_done   <= 1'b1;
                     char_data   <= shreg;
                     stop_ok     <= rx_s;
                     line_hi     <= rx_s;
                     state       <= FR_IDLE;
                  end else begin
                     os_cnt <= os_cnt + 1'b1;
                  end
               end
               default: state <= FR_IDLE;
            endcase
         end
      end
   end

   // R5
   bit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_DATA) |-> (bit_idx < nbits));

   // R5
   one_event_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stb |-> !(evt.is_data && evt.is_stop));

endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
   import uart_rx_pkg::*;
#(
   parameter int DATA_W      = 9,
   parameter int IDLE_CODE_W = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enable,
   input  logic                         restart,
   input  logic                         after_stop,
   input  logic                         muted,
   input  logic [$clog2(DATA_W+1)-1:0]  nbits,
   input  logic [IDLE_CODE_W-1:0]       idle_code,
   input  logic                         start_ok,
   input  bit_evt_t                     evt,
   output logic                         idle_det
);

   localparam int ONES_W    = $clog2(DATA_W+3);
   localparam int MAX_CHARS = 1 << ((1 << IDLE_CODE_W) - 1);
   localparam int CHAR_W    = $clog2(MAX_CHARS+1);

   logic [ONES_W-1:0] ones_cnt;
   logic [CHAR_W-1:0] char_cnt;
   logic              cnt_en;
   logic [ONES_W-1:0] char_bits;
   logic [CHAR_W-1:0] target;
   logic              idle_char;

   always_comb begin
      char_bits = ONES_W'(nbits) + ONES_W'(2);
      target    = CHAR_W'(1) << idle_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_cnt  <= '0;
         char_cnt  <= '0;
         cnt_en    <= 1'b0;
         idle_char <= 1'b0;
         idle_det  <= 1'b0;
      end else begin
         idle_char <= 1'b0;
         idle_det  <= 1'b0;
         if (!enable || restart) begin
            ones_cnt <= '0;
            char_cnt <= '0;
            cnt_en   <= 1'b0;
         end else begin
            if (start_ok) begin
               ones_cnt <= '0;
               char_cnt <= '0;
               cnt_en   <= !after_stop && !muted;
            end else if (evt.stb) begin
               if (evt.is_stop && (after_stop || muted)) begin
                  ones_cnt <= '0;
                  cnt_en   <= 1'b1;
               end else if (cnt_en) begin
                  if (!evt.val) begin
                     ones_cnt <= '0;
                  end else if (ones_cnt == char_bits - 1'b1) begin
                     ones_cnt  <= '0;
                     idle_char <= 1'b1;
                  end else begin
                     ones_cnt <= ones_cnt + 1'b1;
                  end
               end
            end
            if (idle_char && !start_ok) begin
               if (char_cnt == target - 1'b1) begin
                  char_cnt <= '0;
                  idle_det <= 1'b1;
               end else begin
                  char_cnt <= char_cnt + 1'b1;
               end
            end
         end
      end
   end

   // R7
   ones_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_cnt < char_bits);

   // R7
   char_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_cnt < target || !enable || $changed(idle_code));

endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
   import uart_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DATA_W      = 9,
   parameter int IDLE_CODE_W = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    os_tick,
   input  logic                    rx_en,
   input  logic                    rxd_pin,
   input  logic                    tx_loop_in,
   input  logic                    txd_line,
   input  logic                    loop_mode,
   input  logic                    src_sel,
   input  logic                    len7,
   input  logic                    len9,
   input  logic [IDLE_CODE_W-1:0]  idle_code,
   input  logic                    idle_after_stop,
   input  logic                    wake_addr,
   input  logic                    mute_req,
   input  logic                    idle_clr,
   output logic [DATA_W-1:0]       rx_data,
   output logic                    rx_valid,
   output logic                    idle_flag,
   output logic                    frame_err,
   output logic                    muted
);

   localparam int BIT_W = $clog2(DATA_W+1);

   generate
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
      if (DATA_W < 9) begin : g_bad_width
         $error("DATA_W must hold a nine-bit character");
      end
      if (IDLE_CODE_W < 1 || IDLE_CODE_W > 3) begin : g_bad_code
         $error("IDLE_CODE_W must be 1 to 3");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic              rx_s;
   logic              cfg_len7, cfg_len9;
   logic [BIT_W-1:0]  nbits;
   logic              start_ok, char_done, stop_ok, idle_det;
   bit_evt_t          evt;
   logic [DATA_W-1:0] char_data;
   logic              addr_mark, deliver, armed;

   uart_rx_srcmux #(.SYNC_STAGES(SYNC_STAGES)) u_srcmux (
      .clk        (clk),
      .rst_n      (rst_n),
      .loop_mode  (loop_mode),
      .src_sel    (src_sel),
      .rxd_pin    (rxd_pin),
      .tx_loop_in (tx_loop_in),
      .txd_line   (txd_line),
      .rx_s       (rx_s)
   );

   // length selects are captured only while the receiver is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_len7 <= 1'b0;
         cfg_len9 <= 1'b0;
      end else if (!rx_en) begin
         cfg_len7 <= len7;
         cfg_len9 <= len9;
      end
   end

   always_comb begin
      if (cfg_len7)      nbits = BIT_W'(7);
      else if (cfg_len9) nbits = BIT_W'(9);
      else               nbits = BIT_W'(8);
   end

   uart_rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (rx_en),
      .os_tick   (os_tick),
      .rx_s      (rx_s),
      .nbits     (nbits),
      .start_ok  (start_ok),
      .evt       (evt),
      .char_done (char_done),
      .char_data (char_data),
      .stop_ok   (stop_ok)
   );

   uart_rx_idle #(.DATA_W(DATA_W), .IDLE_CODE_W(IDLE_CODE_W)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (rx_en),
      .restart    (mute_req),
      .after_stop (idle_after_stop),
      .muted      (muted),
      .nbits      (nbits),
      .idle_code  (idle_code),
      .start_ok   (start_ok),
      .evt        (evt),
      .idle_det   (idle_det)
   );

   always_comb begin
      addr_mark = char_data[nbits - 1'b1];
      deliver   = char_done && !mute_req && (!muted || (wake_addr && addr_mark));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_valid  <= 1'b0;
         idle_flag <= 1'b0;
         frame_err <= 1'b0;
         muted     <= 1'b0;
         armed     <= 1'b0;
      end else begin
         rx_valid <= deliver;
         if (deliver) rx_data <= char_data;
         if (!rx_en) begin
            idle_flag <= 1'b0;
            frame_err <= 1'b0;
            muted     <= 1'b0;
            armed     <= 1'b0;
         end else begin
            if (deliver && !stop_ok) frame_err <= 1'b1;

            if (mute_req)
               muted <= 1'b1;
            else if (muted && wake_addr && char_done && addr_mark)
               muted <= 1'b0;
            else if (muted && !wake_addr && idle_det)
               muted <= 1'b0;

            if (idle_clr)
               idle_flag <= 1'b0;
            else if (idle_det && armed)
               idle_flag <= 1'b1;

            if (char_done)
               armed <= 1'b1;
            else if (idle_clr || (idle_det && armed))
               armed <= 1'b0;
         end
      end
   end

   // R10
   valid_unmuted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !muted);

   // R9
   idle_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_flag) |-> $past(armed));

   // R9
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_clr |=> !idle_flag);

   // R6
   ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && rx_en) |=> frame_err);

   // R3
   len7_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_len7) |-> (rx_data[DATA_W-1:7] == '0));

   // R4
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_en) |-> $stable(cfg_len7) && $stable(cfg_len9));

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

// File: tb/uart_idle_rx_bench.sv
module uart_idle_rx_bench;

   localparam int BITCLK = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_en = 1'b0;
   logic       rxd_pin = 1'b1, tx_loop_in = 1'b1, txd_line = 1'b1;
   logic       loop_mode = 1'b0, src_sel = 1'b0;
   logic       len7 = 1'b0, len9 = 1'b0;
   logic [2:0] idle_code = 3'd0;
   logic       idle_after_stop = 1'b1;
   logic       wake_addr = 1'b0, mute_req = 1'b0, idle_clr = 1'b0;
   logic [8:0] rx_data;
   logic       rx_valid, idle_flag, frame_err, muted;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   int last_data = 0;

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) os_tick <= 1'b0;
      else        os_tick <= ~os_tick;
   end

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         vcnt++;
         last_data = int'(rx_data);
      end
   end

   uart_idle_rx u_uart_idle_rx (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
      .rxd_pin(rxd_pin), .tx_loop_in(tx_loop_in), .txd_line(txd_line),
      .loop_mode(loop_mode), .src_sel(src_sel), .len7(len7), .len9(len9),
      .idle_code(idle_code), .idle_after_stop(idle_after_stop),
      .wake_addr(wake_addr), .mute_req(mute_req), .idle_clr(idle_clr),
      .rx_data(rx_data), .rx_valid(rx_valid), .idle_flag(idle_flag),
      .frame_err(frame_err), .muted(muted)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_bits(input int n);
      repeat (n * BITCLK) @(negedge clk);
   endtask

   task automatic set_line(input int route, input logic v);
      case (route)
         0:       rxd_pin = v;
         1:       tx_loop_in = v;
         default: txd_line = v;
      endcase
   endtask

   task automatic send_char(input int data, input int n, input bit stop_bit, input int route);
      set_line(route, 1'b0);
      wait_bits(1);
      for (int i = 0; i < n; i++) begin
         set_line(route, data[i]);
         wait_bits(1);
      end
      set_line(route, stop_bit);
      wait_bits(1);
      set_line(route, 1'b1);
   endtask

   task automatic pulse_clr();
      @(negedge clk) idle_clr = 1'b1;
      @(negedge clk) idle_clr = 1'b0;
   endtask

   task automatic pulse_mute();
      @(negedge clk) mute_req = 1'b1;
      @(negedge clk) mute_req = 1'b0;
   endtask

   task automatic reenable();
      @(negedge clk) rx_en = 1'b0;
      repeat (4) @(negedge clk);
      rx_en = 1'b1;
      wait_bits(1);
   endtask

   task automatic t_reset();
      chk(rx_valid == 1'b0,  "R12 rx_valid",  rx_valid, 0);
      chk(idle_flag == 1'b0, "R12 idle_flag", idle_flag, 0);
      chk(frame_err == 1'b0, "R12 frame_err", frame_err, 0);
      chk(muted == 1'b0,     "R12 muted",     muted, 0);
   endtask

   task automatic t_basic();
      int v0 = vcnt;
      send_char(8'hA5, 8, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 + 1, "R5 one valid pulse", vcnt - v0, 1);
      chk(last_data == 'hA5, "R5 data 0xA5", last_data, 'hA5);
      wait_bits(14);
      pulse_clr();
   endtask

   task automatic t_idle_type();
      idle_code = 3'd0;
      idle_after_stop = 1'b0;
      send_char(8'hFF, 8, 1'b1, 0);
      wait_bits(2);
      chk(idle_flag == 1'b1, "R8 early idle after 0xFF", idle_flag, 1);
      wait_bits(12);
      pulse_clr();
      idle_after_stop = 1'b1;
      send_char(8'hFF, 8, 1'b1, 0);
      wait_bits(2);
      chk(idle_flag == 1'b0, "R8 no early idle after stop mode", idle_flag, 0);
      wait_bits(10);
      chk(idle_flag == 1'b1, "R7 one idle char after stop", idle_flag, 1);
      pulse_clr();
   endtask

   task automatic t_idle_count();
      idle_code = 3'd2;
      wait_bits(2);
      send_char(8'h3C, 8, 1'b1, 0);
      wait_bits(35);
      chk(idle_flag == 1'b0, "R7 four idle chars not yet", idle_flag, 0);
      wait_bits(7);
      chk(idle_flag == 1'b1, "R7 four idle chars reached", idle_flag, 1);
      pulse_clr();
      chk(idle_flag == 1'b0, "R9 flag cleared", idle_flag, 0);
      wait_bits(50);
      chk(idle_flag == 1'b0, "R9 no rise without new char", idle_flag, 0);
      send_char(8'h5A, 8, 1'b1, 0);
      wait_bits(42);
      chk(idle_flag == 1'b1, "R9 rearmed by new char", idle_flag, 1);
      pulse_clr();
      idle_code = 3'd0;
   endtask

   task automatic t_len9();
      int v0;
      @(negedge clk) rx_en = 1'b0;
      len9 = 1'b1;
      repeat (4) @(negedge clk);
      rx_en = 1'b1;
      wait_bits(1);
      v0 = vcnt;
      send_char('h1A5, 9, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 + 1 && last_data == 'h1A5, "R3 nine-bit data", last_data, 'h1A5);
      wait_bits(14);
   endtask

   task automatic t_len7();
      @(negedge clk) rx_en = 1'b0;
      len7 = 1'b1;
      repeat (4) @(negedge clk);
      rx_en = 1'b1;
      wait_bits(1);
      len7 = 1'b0;
      len9 = 1'b0;
      send_char('h55, 7, 1'b1, 0);
      wait_bits(1);
      chk(last_data == 'h55, "R4 seven-bit kept while enabled", last_data, 'h55);
      chk(last_data[8:7] == 2'b00, "R3 upper bits zero", last_data, 'h55);
      wait_bits(14);
      reenable();
      wait_bits(1);
   endtask

   task automatic t_routes();
      int v0;
      loop_mode = 1'b1;
      src_sel = 1'b0;
      wait_bits(1);
      rxd_pin = 1'b0;
      txd_line = 1'b0;
      send_char('h5A, 8, 1'b1, 1);
      wait_bits(1);
      chk(last_data == 'h5A, "R1 internal loopback", last_data, 'h5A);
      src_sel = 1'b1;
      txd_line = 1'b1;
      tx_loop_in = 1'b0;
      wait_bits(2);
      send_char('hC3, 8, 1'b1, 2);
      wait_bits(1);
      chk(last_data == 'hC3, "R1 single-wire line", last_data, 'hC3);
      rxd_pin = 1'b1;
      wait_bits(1);
      loop_mode = 1'b0;
      wait_bits(2);
      v0 = vcnt;
      send_char('h96, 8, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 + 1 && last_data == 'h96, "R2 src_sel ignored without loop", last_data, 'h96);
      tx_loop_in = 1'b1;
      txd_line = 1'b1;
      src_sel = 1'b0;
      wait_bits(14);
      pulse_clr();
   endtask

   task automatic t_frame();
      int v0 = vcnt;
      send_char('h33, 8, 1'b0, 0);
      wait_bits(1);
      chk(vcnt == v0 + 1 && last_data == 'h33, "R6 char still delivered", last_data, 'h33);
      chk(frame_err == 1'b1, "R6 frame error set", frame_err, 1);
      wait_bits(4);
      chk(frame_err == 1'b1, "R6 frame error sticky", frame_err, 1);
      reenable();
      chk(frame_err == 1'b0, "R6 cleared by disable", frame_err, 0);
      wait_bits(14);
   endtask

   task automatic t_idle_wake();
      int v0;
      wake_addr = 1'b0;
      idle_code = 3'd0;
      idle_after_stop = 1'b1;
      pulse_mute();
      chk(muted == 1'b1, "R10 mute entered", muted, 1);
      v0 = vcnt;
      send_char('h11, 8, 1'b1, 0);
      send_char('h22, 8, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 && muted == 1'b1, "R10 muted chars suppressed", vcnt - v0, 0);
      wait_bits(11);
      chk(muted == 1'b0, "R10 idle line ends mute", muted, 0);
      send_char('h44, 8, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 + 1 && last_data == 'h44, "R10 data after wake", last_data, 'h44);
      wait_bits(14);
   endtask

   task automatic t_addr_wake();
      int v0;
      wake_addr = 1'b1;
      pulse_mute();
      v0 = vcnt;
      send_char('h12, 8, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 && muted == 1'b1, "R11 unmarked char suppressed", vcnt - v0, 0);
      send_char('h85, 8, 1'b1, 0);
      wait_bits(1);
      chk(vcnt == v0 + 1 && last_data == 'h85, "R11 marked char delivered", last_data, 'h85);
      chk(muted == 1'b0, "R11 mark ends mute", muted, 0);
      wake_addr = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rx_en = 1'b1;
      wait_bits(2);
      t_reset();
      t_basic();
      t_idle_type();
      t_idle_count();
      t_len9();
      t_len7();
      t_routes();
      t_frame();
      t_idle_wake();
      t_addr_wake();
      summary();
      $finish;
   end

endmodule